// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 106 thirty-two-bit control words reached over an APB-style bus with a setup phase and an access phase. Word N sits at byte offset 4·N. Word 0 holds an unlock key. While that word does not hold the key value, writes to the words from byte offset 0x004 through 0x100 are refused. Words at byte offset 0x104 and above stay writable at all times. A fixed group of status words is read-only. One word is intended for writes only, and a read of it is flagged.

When reset is applied, the revision word and the two strap words are loaded from input ports. Every other word is loaded with a fixed constant or with zero. Any access that is refused or malformed raises `pslverr` for the single access cycle. `pready` is always high, so the bus never waits. A `locked` output shows whether the key word currently holds the unlock value.

A small bus state machine tracks the bus phases. It has three states:
- `ST_IDLE`: no transfer is in progress.
- `ST_SETUP`: a setup phase was seen in the previous cycle.
- `ST_ACCESS`: an access was performed in the previous cycle.

Its transitions are as follows:
- A cycle with `psel` high and `penable` low moves the machine to `ST_SETUP`, from any state.
- A cycle in `ST_SETUP` with `psel` and `penable` both high fires the access and moves the machine to `ST_ACCESS`.
- Every other cycle returns the machine to `ST_IDLE`.

Top module: `key_ctl_regfile`

## Requirements
- R1: The word index is `paddr[11:2]`. The bank holds words 0 to 105, so the last valid byte offset is 0x1A4. A word that accepts a write returns the written value on a later read.
- R2: A read at byte offset 0x1A8 or above returns zero and raises `pslverr`. A write at those offsets changes no word and raises `pslverr`.
- R3: The key word is at offset 0x000. It resets to zero, it accepts any full-word write whatever the lock state, and it stores all 32 bits.
- R4: A write to offsets 0x004 through 0x100 is performed only when the key word holds 0x1688A8A8. Otherwise the write is discarded and `pslverr` is raised.
- R5: Writes to the read-only offsets are discarded and raise `pslverr`. The read-only offsets are 0x014, 0x050 through 0x06C, 0x078, 0x07C, 0x0E0 and 0x0E4.
- R6: Offset 0x0C0 accepts writes. A read of offset 0x0C0 returns its stored value and raises `pslverr`.
- R7: Reset loads three words from input ports: offset 0x07C from `rev_in`, offset 0x070 from `strap_a` and offset 0x0D0 from `strap_b`.
- R8: Reset loads fixed constants into five words: 0x004 = 0xFFCFFEDC, 0x008 = 0xF3F40000, 0x03C = 0x00000001, 0x040 = 0x000000C0 and 0x1A4 = 0x00002402. Every other word resets to zero.
- R9: An access with `paddr[1:0]` not zero raises `pslverr` and returns zero. The same applies to a write whose `pstrb` is not 4'hF. No word changes in either case.
- R10: `locked` is high exactly when the key word differs from 0x1688A8A8. Writing any other value to the key word raises `locked` in the next cycle.
- R11: An access fires only in a cycle with `psel` and `penable` high that follows a setup cycle (`psel` high, `penable` low). `pready` is always 1. `pslverr` is high only in a cycle where an access fires.
- R12: Writes to offsets 0x104 through 0x1A4 are performed whether or not the bank is locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes, all must be set on writes |
| prdata | output | 32 | Read data, valid in the access cycle |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error for refused or malformed access |
| rev_in | input | 32 | Revision value loaded at reset |
| strap_a | input | 32 | First strap value loaded at reset |
| strap_b | input | 32 | Second strap value loaded at reset |
| locked | output | 1 | High while the key word differs from the unlock value |

## Verification
The bench probes both edges of the gated range, offset 0x100 (gated) and offset 0x104 (free). A design with the wrong boundary either lets a locked write through to the last gated word or rejects the first free one. It writes to read-only offsets and to the key word, then reads each word back. A missing read-only check shows as a changed status word. A relock that only compares some key bits shows as writes accepted after a non-key value is written. The bench also reads at offset 0x1A8, writes with partial strobes, and reads the write-only word. A decoder that wraps the index, ignores strobes, or forgets the flag on the write-only read returns wrong data or no error.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

    // Bus phase tracker states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } bus_state_e;

    // Per-access address classification
    typedef struct packed {
        logic in_range;
        logic aligned;
        logic gated;
        logic read_only;
        logic write_only;
    } addr_class_t;

    // Word indices with special behaviour
    localparam int unsigned IDX_KEY     = 0;
    localparam int unsigned IDX_STRAP_A = 28;   // byte 0x070
    localparam int unsigned IDX_REV     = 31;   // byte 0x07C
    localparam int unsigned IDX_WONLY   = 48;   // byte 0x0C0
    localparam int unsigned IDX_STRAP_B = 52;   // byte 0x0D0

    function automatic logic is_read_only(input int unsigned idx);
        return (idx == 5) || (idx >= 20 && idx <= 27) || (idx == 30) ||
               (idx == 31) || (idx == 56) || (idx == 57);
    endfunction

    function automatic logic [31:0] reset_word(input int unsigned idx);
        logic [31:0] v;
        unique case (idx)
            1:       v = 32'hFFCF_FEDC;
            2:       v = 32'hF3F4_0000;
            15:      v = 32'h0000_0001;
            16:      v = 32'h0000_00C0;
            105:     v = 32'h0000_2402;
            default: v = 32'h0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/kcr_bus_fsm.sv
module kcr_bus_fsm
    import kcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psel,
    input  logic       penable,
    output logic       fire,
    output bus_state_e state
);

    bus_state_e state_q;
    bus_state_e state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ACCESS: begin
                if (psel && !penable) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (psel && penable)       state_d = ST_ACCESS;
                else if (psel && !penable) state_d = ST_SETUP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fire  = (state_q == ST_SETUP) && psel && penable;
        state = state_q;
    end

    AST_ACCESS_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(psel && !penable)); // R11

endmodule

// File: rtl/kcr_addr_decode.sv
module kcr_addr_decode
    import kcr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned NUM_WORDS    = 106,
    parameter int unsigned GATE_END_IDX = 65,
    localparam int unsigned IDX_W       = $clog2(NUM_WORDS)
)(
    input  logic [ADDR_W-1:0] paddr,
    output logic [IDX_W-1:0]  idx,
    output addr_class_t       cls
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    int unsigned       word_n;

    always_comb begin
        word   = paddr[ADDR_W-1:2];
        word_n = 32'(word);
        idx    = word[IDX_W-1:0];
        cls.in_range   = word_n < NUM_WORDS;
        cls.aligned    = paddr[1:0] == 2'b00;
        cls.gated      = (word_n > IDX_KEY) && (word_n < GATE_END_IDX);
        cls.read_only  = is_read_only(word_n);
        cls.write_only = word_n == IDX_WONLY;
    end

endmodule

// File: rtl/kcr_reg_bank.sv
module kcr_reg_bank
    import kcr_pkg::*;
#(
    parameter int unsigned NUM_WORDS    = 106,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned GATE_END_IDX = 65,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1688_A8A8,
    localparam int unsigned IDX_W       = $clog2(NUM_WORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rev_in,
    input  logic [DATA_W-1:0] strap_a,
    input  logic [DATA_W-1:0] strap_b,
    output logic [DATA_W-1:0] rd_data,
    output logic              key_ok
);

    logic [DATA_W-1:0] words [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] rst_val;

        if (i == IDX_REV) begin : g_rev
            assign rst_val = rev_in;
        end else if (i == IDX_STRAP_A) begin : g_sa
            assign rst_val = strap_a;
        end else if (i == IDX_STRAP_B) begin : g_sb
            assign rst_val = strap_b;
        end else begin : g_const
            assign rst_val = DATA_W'(reset_word(i));
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                               q <= rst_val;
            else if (wr_en && wr_idx == IDX_W'(i))    q <= wr_data;
        end

        assign words[i] = q;
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < NUM_WORDS) rd_data = words[rd_idx];
        key_ok = words[0] == UNLOCK_KEY;
    end

    AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(wr_idx) > 0 && 32'(wr_idx) < GATE_END_IDX) |-> key_ok); // R4

    AST_RO_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(words[5])); // R5

    AST_RO_REV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(words[IDX_REV])); // R5

endmodule

// File: rtl/key_ctl_regfile.sv
module key_ctl_regfile
    import kcr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned NUM_WORDS    = 106,
    parameter int unsigned GATE_END_IDX = 65,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1688_A8A8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W/8-1:0] pstrb,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [DATA_W-1:0] rev_in,
    input  logic [DATA_W-1:0] strap_a,
    input  logic [DATA_W-1:0] strap_b,
    output logic              locked
);

    localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
    localparam int unsigned STRB_W = DATA_W / 8;

    logic              fire;
    bus_state_e        bus_state;
    logic [IDX_W-1:0]  idx;
    addr_class_t       cls;
    logic [DATA_W-1:0] bank_rd;
    logic              key_ok;
    logic              shape_ok;
    logic              refused;
    logic              wr_en;

    kcr_bus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .fire    (fire),
        .state   (bus_state)
    );

    kcr_addr_decode #(
        .ADDR_W       (ADDR_W),
        .NUM_WORDS    (NUM_WORDS),
        .GATE_END_IDX (GATE_END_IDX)
    ) u_dec (
        .paddr (paddr),
        .idx   (idx),
        .cls   (cls)
    );

    kcr_reg_bank #(
        .NUM_WORDS    (NUM_WORDS),
        .DATA_W       (DATA_W),
        .GATE_END_IDX (GATE_END_IDX),
        .UNLOCK_KEY   (UNLOCK_KEY)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (pwdata),
        .rd_idx  (idx),
        .rev_in  (rev_in),
        .strap_a (strap_a),
        .strap_b (strap_b),
        .rd_data (bank_rd),
        .key_ok  (key_ok)
    );

    always_comb begin
        shape_ok = cls.aligned && (!pwrite || pstrb == {STRB_W{1'b1}});
        if (pwrite)
            refused = !shape_ok || !cls.in_range || cls.read_only ||
                      (cls.gated && !key_ok);
        else
            refused = !shape_ok || !cls.in_range || cls.write_only;
        wr_en   = fire && pwrite && !refused;
        pslverr = fire && refused;
        pready  = 1'b1;
        prdata  = '0;
        if (fire && !pwrite && shape_ok && cls.in_range) prdata = bank_rd;
        locked  = !key_ok;
    end

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !pwrite && !cls.in_range) |-> (prdata == '0 && pslverr)); // R2

    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pwrite && paddr == '0 && pstrb == {STRB_W{1'b1}} &&
         pwdata != UNLOCK_KEY) |=> locked); // R10

    AST_STRB_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pwrite && pstrb != {STRB_W{1'b1}}) |-> (pslverr && !wr_en)); // R9

    AST_ERR_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (bus_state == ST_SETUP && penable)); // R11

endmodule

// File: tb/tb_key_ctl_regfile.sv
`timescale 1ns/1ps
module tb_key_ctl_regfile;

    localparam logic [31:0] KEY   = 32'h1688_A8A8;
    localparam logic [31:0] REV   = 32'h0200_0303;
    localparam logic [31:0] SA    = 32'hA5A5_0F0F;
    localparam logic [31:0] SB    = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, locked;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    key_ctl_regfile dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .rev_in(REV), .strap_a(SA), .strap_b(SB), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] s, output logic [31:0] rd, output logic er);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        #1;
        if (pslverr !== 1'b0) begin errors++; $display("FAIL R11: actual %b expected 0 in setup", pslverr); end
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; er = pslverr;
        chk("R11 ready", {31'b0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic exp_err, input string req);
        logic [31:0] rd; logic er;
        access(1'b1, a, d, 4'hF, rd, er);
        chk(req, {31'b0, er}, {31'b0, exp_err});
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input logic exp_err, input string req);
        logic [31:0] rd; logic er;
        access(1'b0, a, 32'h0, 4'h0, rd, er);
        chk(req, rd, exp);
        chk(req, {31'b0, er}, {31'b0, exp_err});
    endtask

    task automatic t_reset;
        rd_chk(12'h000, 32'h0, 1'b0, "R3 key reset");
        rd_chk(12'h004, 32'hFFCF_FEDC, 1'b0, "R8 0x004");
        rd_chk(12'h008, 32'hF3F4_0000, 1'b0, "R8 0x008");
        rd_chk(12'h03C, 32'h1, 1'b0, "R8 0x03C");
        rd_chk(12'h040, 32'hC0, 1'b0, "R8 0x040");
        rd_chk(12'h1A4, 32'h2402, 1'b0, "R8 0x1A4 R1 last word");
        rd_chk(12'h030, 32'h0, 1'b0, "R8 zero word");
        rd_chk(12'h07C, REV, 1'b0, "R7 rev");
        rd_chk(12'h070, SA, 1'b0, "R7 strap_a");
        rd_chk(12'h0D0, SB, 1'b0, "R7 strap_b");
        chk("R10 locked at reset", {31'b0, locked}, 32'd1);
    endtask

    task automatic t_locked;
        wr(12'h008, 32'hDEAD_BEEF, 1'b1, "R4 locked write err");
        rd_chk(12'h008, 32'hF3F4_0000, 1'b0, "R4 locked unchanged");
        wr(12'h100, 32'h1111_2222, 1'b1, "R4 gate edge 0x100");
        rd_chk(12'h100, 32'h0, 1'b0, "R4 0x100 unchanged");
        wr(12'h104, 32'h3333_4444, 1'b0, "R12 0x104 free");
        rd_chk(12'h104, 32'h3333_4444, 1'b0, "R12 0x104 readback");
        wr(12'h1A0, 32'h5555_6666, 1'b0, "R12 0x1A0 free");
        rd_chk(12'h1A0, 32'h5555_6666, 1'b0, "R12 R1 0x1A0 readback");
    endtask

    task automatic t_unlock;
        wr(12'h000, KEY, 1'b0, "R3 key write");
        chk("R10 unlocked", {31'b0, locked}, 32'd0);
        rd_chk(12'h000, KEY, 1'b0, "R3 key stored");
        wr(12'h008, 32'hDEAD_BEEF, 1'b0, "R4 unlocked write");
        rd_chk(12'h008, 32'hDEAD_BEEF, 1'b0, "R4 R1 readback");
        wr(12'h100, 32'h1111_2222, 1'b0, "R4 0x100 unlocked");
        rd_chk(12'h100, 32'h1111_2222, 1'b0, "R4 0x100 readback");
    endtask

    task automatic t_read_only;
        wr(12'h014, 32'hFFFF_FFFF, 1'b1, "R5 0x014 err");
        rd_chk(12'h014, 32'h0, 1'b0, "R5 0x014 unchanged");
        wr(12'h060, 32'hFFFF_FFFF, 1'b1, "R5 0x060 err");
        rd_chk(12'h060, 32'h0, 1'b0, "R5 0x060 unchanged");
        wr(12'h07C, 32'h0, 1'b1, "R5 0x07C err");
        rd_chk(12'h07C, REV, 1'b0, "R5 0x07C unchanged");
        wr(12'h0E4, 32'h1, 1'b1, "R5 0x0E4 err");
        rd_chk(12'h0E4, 32'h0, 1'b0, "R5 0x0E4 unchanged");
    endtask

    task automatic t_write_only;
        wr(12'h0C0, 32'hCAFE_0001, 1'b0, "R6 write ok");
        rd_chk(12'h0C0, 32'hCAFE_0001, 1'b1, "R6 read value+err");
    endtask

    task automatic t_range_shape;
        logic [31:0] rd; logic er;
        rd_chk(12'h1A8, 32'h0, 1'b1, "R2 oor read");
        wr(12'h1A8, 32'h7777_7777, 1'b1, "R2 oor write err");
        rd_chk(12'h000, KEY, 1'b0, "R2 no alias to key");
        rd_chk(12'h009, 32'h0, 1'b1, "R9 misaligned read");
        access(1'b1, 12'h008, 32'h0101_0101, 4'h7, rd, er);
        chk("R9 partial strobe err", {31'b0, er}, 32'd1);
        rd_chk(12'h008, 32'hDEAD_BEEF, 1'b0, "R9 unchanged");
        access(1'b1, 12'h00A, 32'h0202_0202, 4'hF, rd, er);
        chk("R9 misaligned write err", {31'b0, er}, 32'd1);
        rd_chk(12'h008, 32'hDEAD_BEEF, 1'b0, "R9 unchanged 2");
    endtask

    task automatic t_no_setup;
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h108; pwdata = 32'h9; pstrb = 4'hF;
        #1;
        chk("R11 no error without setup", {31'b0, pslverr}, 32'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        rd_chk(12'h108, 32'h0, 1'b0, "R11 no write without setup");
    endtask

    task automatic t_relock;
        wr(12'h000, KEY ^ 32'h8000_0000, 1'b0, "R10 relock write");
        chk("R10 locked again", {31'b0, locked}, 32'd1);
        wr(12'h008, 32'h0, 1'b1, "R10 gated after relock");
        rd_chk(12'h008, 32'hDEAD_BEEF, 1'b0, "R10 unchanged");
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_unlock();
        t_read_only();
        t_write_only();
        t_range_shape();
        t_no_setup();
        t_relock();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule